// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator with Snapshot

This block gathers single-cycle event pulses coming from a serial-bus controller (mailbox traffic and boot-load outcomes) and folds them into three maskable interrupt status bits. Those bits drive one combined, registered interrupt line to the system interrupt controller. Each event is held in four places:

- a sticky event bit;
- an event enable;
- a "new since last look" bit;
- a snapshot copy.

Software reaches all of these through a small register port. The port has a combinational read path and supports write-one-to-clear and write-one-to-set operations.

Reading the status register has a side effect. It captures the pending new-event bits into the snapshot register and then clears them, so the handler sees a stable picture of what arrived. Writing 1 to a status bit acknowledges it. This clears every enabled event that feeds that bit. A separate set register lets software force status bits to test the interrupt path.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A 1 on `evt_pulse[i]` sets event bit i and new-event bit i at the next clock edge. Event bits are: 0 outgoing-mailbox read, 1 incoming-mailbox write, 2 load timeout, 3 load error, 4 load size error, 5 load no-device.
- R3: Writing address 0 (event register) clears each event bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: Writing address 2 (new-event register) clears each new-event bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: Status is read at address 4 and is formed as follows. Status bit 0 (outgoing mailbox empty) is event 0 AND enable 0. Status bit 1 (incoming mailbox full) is event 1 AND enable 1. Status bit 2 (load fail) is the OR of events 2 to 5, each ANDed with its enable. The sticky set bit is ORed into each status bit. Enables are read and written at address 1.
- R6: A read of address 4 copies the new-event bits, as they stood before that edge, into the snapshot (address 3). It also clears the new-event bits.
- R7: Writing 1 to status bit s (address 4) clears every enabled event related to s and clears set bit s. Disabled related events keep their value.
- R8: Writing 1 to bit s of address 5 makes set bit s sticky, which forces status bit s. Address 5 reads back the set bits.
- R9: `irq` equals the OR over status bits ANDed with the interrupt enables (address 6, bits 0 to 2), registered one cycle later.
- R10: A pulse in the same cycle as any clear of that bit (event write, new-event write, status write, status read) leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 6 | Single-cycle event pulses |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect at address 4) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational read data |
| irq | output | 1 | Registered combined interrupt |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a hardware event pulse and a software clear of the same bit. The second is a pulse arriving during the status read that snapshots and clears the new-event bits. Directed steps place a pulse on exactly the cycle of an event write, a new-event write, a status acknowledge and a status read. Random stimulus also produces many such overlaps. A bench model judges each cycle under the rule that the set wins and that the snapshot takes the pre-edge new-event value.

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    evt_pulse,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int NE = 6;
  localparam int NS = 3;
  localparam logic [2:0] A_EVT = 3'd0, A_EN = 3'd1, A_NEW = 3'd2, A_SNAP = 3'd3,
                         A_STAT = 3'd4, A_SET = 3'd5, A_IEN = 3'd6;

  logic [NE-1:0] evt_q, en_q, new_q, snap_q;
  logic [NS-1:0] set_q, ien_q;
  logic          irq_q;

  wire wr_evt  = reg_wr && reg_addr == A_EVT;
  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire wr_new  = reg_wr && reg_addr == A_NEW;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_set  = reg_wr && reg_addr == A_SET;
  wire wr_ien  = reg_wr && reg_addr == A_IEN;
  wire rd_stat = reg_rd && reg_addr == A_STAT;

  wire [NE-1:0] ev_on  = evt_q & en_q;
  wire [NS-1:0] stat   = {|ev_on[5:2], ev_on[1], ev_on[0]} | set_q;
  wire [NS-1:0] st_clr = wr_stat ? reg_wdata[NS-1:0] : '0;
  wire [NE-1:0] evt_clr = (wr_evt ? reg_wdata[NE-1:0] : '0)
                        | ({{4{st_clr[2]}}, st_clr[1], st_clr[0]} & en_q);
  wire [NE-1:0] new_clr = (wr_new ? reg_wdata[NE-1:0] : '0) | {NE{rd_stat}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      en_q   <= '0;
      new_q  <= '0;
      snap_q <= '0;
      set_q  <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~evt_clr) | evt_pulse;
      new_q <= (new_q & ~new_clr) | evt_pulse;
      if (rd_stat) snap_q <= new_q;
      if (wr_en)   en_q   <= reg_wdata[NE-1:0];
      if (wr_ien)  ien_q  <= reg_wdata[NS-1:0];
      set_q <= (set_q & ~st_clr) | (wr_set ? reg_wdata[NS-1:0] : '0);
      irq_q <= |(stat & ien_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EVT:   reg_rdata[NE-1:0] = evt_q;
      A_EN:    reg_rdata[NE-1:0] = en_q;
      A_NEW:   reg_rdata[NE-1:0] = new_q;
      A_SNAP:  reg_rdata[NE-1:0] = snap_q;
      A_STAT:  reg_rdata[NS-1:0] = stat;
      A_SET:   reg_rdata[NS-1:0] = set_q;
      A_IEN:   reg_rdata[NS-1:0] = ien_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R2 and R10: a pulse always lands in both the sticky and new copies
  a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> (((evt_q & new_q) & $past(evt_pulse)) == $past(evt_pulse)));
  a_r3_w1c_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && evt_pulse == '0) |=> ((evt_q & $past(reg_wdata[NE-1:0])) == '0));
  a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (snap_q == $past(new_q)));
  a_r6_new_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (new_q == $past(evt_pulse)));
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |=> !irq);
endmodule

// File: tb/evt_irq_agg_tb.sv
`timescale 1ns/1ps
module evt_irq_agg_tb;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0;
  logic [5:0] evt_pulse = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  evt_irq_agg #(.DW(DW)) u_dut (.clk, .rst_n, .evt_pulse, .reg_addr, .reg_wr,
    .reg_rd, .reg_wdata, .reg_rdata, .irq);

  always #2 clk = ~clk;

  logic [5:0] m_evt, m_en, m_new, m_snap;
  logic [2:0] m_set, m_ien;
  logic m_irq;

  function automatic logic [2:0] f_stat(logic [5:0] e, logic [5:0] n, logic [2:0] s);
    logic [5:0] a;
    a = e & n;
    return {|a[5:2], a[1], a[0]} | s;
  endfunction

  function automatic logic [7:0] f_read(logic [2:0] a);
    case (a)
      3'd0: return {2'b0, m_evt};
      3'd1: return {2'b0, m_en};
      3'd2: return {2'b0, m_new};
      3'd3: return {2'b0, m_snap};
      3'd4: return {5'b0, f_stat(m_evt, m_en, m_set)};
      3'd5: return {5'b0, m_set};
      3'd6: return {5'b0, m_ien};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, logic [5:0] p, logic wr, logic rd,
                      logic [2:0] a, logic [7:0] d);
    logic [2:0] st, sc;
    logic [5:0] ec, nc;
    @(negedge clk);
    evt_pulse = p; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
    check({tag, " irq (R9)"}, {7'b0, irq}, {7'b0, m_irq});
    if (rd) check(tag, reg_rdata, f_read(a));
    @(posedge clk);
    st = f_stat(m_evt, m_en, m_set);
    sc = (wr && a == 3'd4) ? d[2:0] : 3'b0;
    ec = ((wr && a == 3'd0) ? d[5:0] : 6'b0) | ({{4{sc[2]}}, sc[1], sc[0]} & m_en);
    nc = ((wr && a == 3'd2) ? d[5:0] : 6'b0) | ((rd && a == 3'd4) ? 6'h3F : 6'h00);
    m_irq = |(st & m_ien);
    if (rd && a == 3'd4) m_snap = m_new;
    m_evt = (m_evt & ~ec) | p;
    m_new = (m_new & ~nc) | p;
    m_set = (m_set & ~sc) | ((wr && a == 3'd5) ? d[2:0] : 3'b0);
    if (wr && a == 3'd1) m_en = d[5:0];
    if (wr && a == 3'd6) m_ien = d[2:0];
  endtask

  task automatic rd(string tag, logic [2:0] a);
    step(tag, 6'h00, 1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [7:0] d, logic [5:0] p = 6'h00);
    step(tag, p, 1'b1, 1'b0, a, d);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    {m_evt, m_en, m_new, m_snap, m_set, m_ien, m_irq} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < 7; a++) rd("R1 reset", 3'(a));
    // R2: pulse on load error sets event and new bits
    step("R2 pulse", 6'h08, 1'b0, 1'b0, 3'd0, 8'h00);
    rd("R2 event", 3'd0);
    rd("R2 new", 3'd2);
    // R3: zero writes nothing, one clears
    wr("R3 w0", 3'd0, 8'h00);
    rd("R3 keep", 3'd0);
    wr("R3 w1", 3'd0, 8'h08);
    rd("R3 clear", 3'd0);
    // R4
    wr("R4 w0", 3'd2, 8'h00);
    rd("R4 keep", 3'd2);
    wr("R4 w1", 3'd2, 8'h08);
    rd("R4 clear", 3'd2);
    // R5: mapping with enables
    wr("R5 en", 3'd1, 8'h3D);
    rd("R5 en rb", 3'd1);
    step("R5 pulse", 6'h32, 1'b0, 1'b0, 3'd0, 8'h00);
    rd("R5 status", 3'd4);
    // R6: snapshot taken and new cleared by that read
    rd("R6 snap", 3'd3);
    rd("R6 new", 3'd2);
    // R7: acknowledge load fail with bit 4 disabled
    wr("R7 en", 3'd1, 8'h0C);
    step("R7 pulse", 6'h1C, 1'b0, 1'b0, 3'd0, 8'h00);
    wr("R7 ack", 3'd4, 8'h04);
    rd("R7 evt left", 3'd0);
    // R8 and R9
    wr("R9 ien", 3'd6, 8'h07);
    wr("R8 set", 3'd5, 8'h01);
    rd("R8 set rb", 3'd5);
    rd("R8 status", 3'd4);
    wr("R7 set clr", 3'd4, 8'h01);
    rd("R7 set gone", 3'd5);
    rd("R9 irq", 3'd4);
    // R10: pulse coincides with each clear
    wr("R10 evt", 3'd0, 8'h02, 6'h02);
    rd("R10 evt rb", 3'd0);
    wr("R10 new", 3'd2, 8'h02, 6'h02);
    rd("R10 new rb", 3'd2);
    wr("R10 en", 3'd1, 8'h3F);
    wr("R10 ack", 3'd4, 8'h02, 6'h02);
    rd("R10 ack rb", 3'd0);
    step("R10 rdstat", 6'h20, 1'b0, 1'b1, 3'd4, 8'h00);
    rd("R10 new after rd", 3'd2);
    rd("R10 snap", 3'd3);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [5:0] p;
      int k;
      a = 3'($urandom_range(0, 6));
      p = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h00;
      k = $urandom_range(0, 2);
      if (k == 0) step("R9 rnd idle", p, 1'b0, 1'b0, a, 8'h00);
      else if (k == 1) step(a == 0 ? "R3 rnd" : a == 2 ? "R4 rnd" : a == 3 ? "R6 rnd" :
                            a == 5 ? "R8 rnd" : a == 6 ? "R9 rnd" : "R5 rnd",
                            p, 1'b0, 1'b1, a, 8'h00);
      else step("R7 rnd wr", p, 1'b1, 1'b0, a, 8'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule